// File: doc/BRIEF.md
# Flash Timing Clock Divider with Write-Once Configuration

This block derives the slow time base that a flash command engine uses to time its program and erase pulses. Software programs a divide value and an optional divide-by-8 prescale through a small register port. The resulting timing period, measured in bus clock cycles, is `(prescale ? 8 : 1) × (DIV + 1)`. Software must choose these values so that the timing clock lies between 150 kHz and 200 kHz. The divider register can be loaded only once after each reset. The load is refused while an access error is pending, and a refused write does not use up the single allowed load.

Until the divider is loaded, the timing tick stays silent and every command start is turned away with an access error. After the divider is loaded, an accepted start runs a pulse timer. The timer counts whole timing periods: a fixed number of them for a program command and another fixed number for an erase command. When the count is reached, the timer gives a one-cycle done pulse.

A controller with four states sequences the block:
- `ST_UNCONF`: divider not loaded.
- `ST_IDLE`: ready for a command.
- `ST_RUN`: pulse being timed.
- `ST_FINISH`: one-cycle completion.

The transitions are:
- `ST_UNCONF` to `ST_IDLE` on an accepted divider write.
- `ST_IDLE` to `ST_RUN` on a command start.
- `ST_RUN` to `ST_FINISH` when the tick count is reached.
- `ST_FINISH` to `ST_IDLE` unconditionally.

Reset returns the block to `ST_UNCONF` from any state.

Top module: `fclk_timebase`

## Requirements
- R1: After reset, the divider register (`reg_sel`=0) and the status register (`reg_sel`=1) both read 0, `tick` is 0 and `pulse_busy` is 0.
- R2: The first divider write after reset that occurs with no access error pending loads bits 5:0 (divide value) and bit 6 (prescale enable). From then on, bit 7 (loaded flag, read-only) reads 1.
- R3: Every divider write after the first accepted one is ignored: the readback does not change.
- R4: A divider write while the access-error flag is set is ignored, and the register stays unloaded. A later write, made after the flag is cleared, is accepted.
- R5: `tick` stays 0 while the divider is unloaded.
- R6: After a load in bus cycle 0, `tick` is high in exactly the cycles n>0 with n a multiple of P. P = (bit6 ? 8 : 1) × (bits5:0 + 1). Each tick lasts one cycle.
- R7: A command start while the divider is unloaded keeps `cmd_accept` low and sets the access-error flag, which is status bit 4.
- R8: Writing status with bit 4 = 1 clears the access-error flag. Writing 0 in bit 4 leaves it set.
- R9: With the divider loaded and the block idle, `cmd_accept` is high in the same cycle as `cmd_start`.
- R10: After an accepted start, `pulse_busy` stays high until the timer has counted PROG_TICKS ticks (`cmd_kind`=0) or ERASE_TICKS ticks (`cmd_kind`=1). `pulse_done` is then high for one cycle, the cycle after the last counted tick.
- R11: A start while busy is not accepted and does not set the access-error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 divider, 1 status |
| reg_wdata | input | DIV_W+2 | Write data |
| reg_rdata | output | DIV_W+2 | Readback of the selected register |
| cmd_start | input | 1 | Program or erase start request |
| cmd_kind | input | 1 | 0 program, 1 erase |
| tick | output | 1 | One-cycle pulse per timing period |
| cmd_accept | output | 1 | Start request accepted this cycle |
| pulse_busy | output | 1 | Pulse timer running |
| pulse_done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following properties on every cycle:
- The loaded flag is sticky, and the divider fields never move once the flag is set.
- No tick appears while the divider is unloaded.
- An early start always raises the error flag, and an error blocks the load.
- No start is accepted unless the block is loaded and idle, and the done pulse is single and follows busy.

The exact tick phase and period for each divide setting, and the exact number of ticks timed per command kind, can only be shown by the bench scenarios. The same holds for the cleanup path where a 0 write leaves the error set and a 1 write clears it. The bench sweeps every prescale and divide combination from 0 to 7, plus the largest divide value.

// File: rtl/fclk_pkg.sv
package fclk_pkg;

    typedef enum logic [1:0] {
        ST_UNCONF = 2'd0,
        ST_IDLE   = 2'd1,
        ST_RUN    = 2'd2,
        ST_FINISH = 2'd3
    } fclk_state_e;

    localparam int STAT_ERR_BIT = 4;

endpackage

// File: rtl/fclk_divider.sv
module fclk_divider #(
    parameter int DIV_W     = 6,
    parameter int PRE_RATIO = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    input  logic             pre_en,
    output logic             tick
);
    localparam int PRE_W = $clog2(PRE_RATIO);

    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic             pre_wrap;
    logic             period_end;

    assign pre_wrap   = !pre_en || (pre_cnt == PRE_W'(PRE_RATIO - 1));
    assign period_end = pre_wrap && (div_cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            div_cnt <= '0;
            tick    <= 1'b0;
        end else if (!run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
            tick    <= 1'b0;
        end else begin
            pre_cnt <= pre_wrap ? '0 : pre_cnt + PRE_W'(1);
            if (pre_wrap) begin
                div_cnt <= period_end ? '0 : div_cnt + DIV_W'(1);
            end
            tick <= period_end;
        end
    end

endmodule

// File: rtl/fclk_pulse_timer.sv
module fclk_pulse_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             count_en,
    input  logic             tick,
    input  logic [CNT_W-1:0] target,
    output logic             hit
);
    logic [CNT_W-1:0] cnt;

    assign hit = count_en && tick && (cnt == target - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (count_en && tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/fclk_timebase.sv
module fclk_timebase
    import fclk_pkg::*;
#(
    parameter int DIV_W       = 6,
    parameter int PRE_RATIO   = 8,
    parameter int PROG_TICKS  = 20,
    parameter int ERASE_TICKS = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [DIV_W+1:0] reg_wdata,
    output logic [DIV_W+1:0] reg_rdata,
    input  logic             cmd_start,
    input  logic             cmd_kind,
    output logic             tick,
    output logic             cmd_accept,
    output logic             pulse_busy,
    output logic             pulse_done
);
    localparam int REG_W      = DIV_W + 2;
    localparam int PRE_BIT    = DIV_W;
    localparam int LOADED_BIT = DIV_W + 1;
    localparam int MAX_TICKS  = (PROG_TICKS > ERASE_TICKS) ? PROG_TICKS : ERASE_TICKS;
    localparam int CNT_W      = $clog2(MAX_TICKS + 1);

    fclk_state_e      state, state_nx;
    logic [DIV_W-1:0] div_q;
    logic             pre_q;
    logic             acc_err;
    logic             kind_q;
    logic             loaded;
    logic             div_wr;
    logic             stat_wr;
    logic             div_take;
    logic             count_en;
    logic             hit;
    logic [CNT_W-1:0] target;
    logic             unused_wdata;

    assign div_wr       = reg_wr && !reg_sel;
    assign stat_wr      = reg_wr && reg_sel;
    assign unused_wdata = reg_wdata[LOADED_BIT];
    assign target       = kind_q ? CNT_W'(ERASE_TICKS) : CNT_W'(PROG_TICKS);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_UNCONF;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_UNCONF: if (div_wr && !acc_err) state_nx = ST_IDLE;
            ST_IDLE:   if (cmd_start)          state_nx = ST_RUN;
            ST_RUN:    if (hit)                state_nx = ST_FINISH;
            ST_FINISH:                         state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        loaded     = 1'b1;
        div_take   = 1'b0;
        cmd_accept = 1'b0;
        pulse_busy = 1'b0;
        pulse_done = 1'b0;
        count_en   = 1'b0;
        unique case (state)
            ST_UNCONF: begin
                loaded   = 1'b0;
                div_take = div_wr && !acc_err;
            end
            ST_IDLE:   cmd_accept = cmd_start;
            ST_RUN: begin
                pulse_busy = 1'b1;
                count_en   = 1'b1;
            end
            ST_FINISH: pulse_done = 1'b1;
        endcase
    end

    // Configuration and status registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= '0;
            pre_q   <= 1'b0;
            acc_err <= 1'b0;
            kind_q  <= 1'b0;
        end else begin
            if (div_take) begin
                div_q <= reg_wdata[DIV_W-1:0];
                pre_q <= reg_wdata[PRE_BIT];
            end
            if (cmd_start && !loaded)
                acc_err <= 1'b1;
            else if (stat_wr && reg_wdata[STAT_ERR_BIT])
                acc_err <= 1'b0;
            if (cmd_accept)
                kind_q <= cmd_kind;
        end
    end

    always_comb begin
        if (reg_sel) begin
            reg_rdata               = '0;
            reg_rdata[STAT_ERR_BIT] = acc_err;
        end else begin
            reg_rdata = {loaded, pre_q, div_q};
        end
    end

    fclk_divider #(
        .DIV_W     (DIV_W),
        .PRE_RATIO (PRE_RATIO)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (loaded),
        .div    (div_q),
        .pre_en (pre_q),
        .tick   (tick)
    );

    fclk_pulse_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cmd_accept),
        .count_en (count_en),
        .tick     (tick),
        .target   (target),
        .hit      (hit)
    );

endmodule

// File: rtl/fclk_timebase_chk.sv
module fclk_timebase_chk #(
    parameter int DIV_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             loaded,
    input logic             acc_err,
    input logic             tick,
    input logic [DIV_W-1:0] div_q,
    input logic             pre_q,
    input logic             reg_wr,
    input logic             reg_sel,
    input logic             cmd_start,
    input logic             cmd_accept,
    input logic             pulse_busy,
    input logic             pulse_done
);
    a_r2_loaded_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        loaded |=> loaded);

    a_r3_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        loaded |=> ($stable(div_q) && $stable(pre_q)));

    a_r4_err_blocks_load: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_err && !loaded && reg_wr && !reg_sel) |=> !loaded);

    a_r5_silent_unloaded: assert property (@(posedge clk) disable iff (!rst_n)
        !loaded |-> !tick);

    a_r7_early_start_err: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !loaded) |=> acc_err);

    a_r9_accept_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |-> (loaded && cmd_start));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_done |=> !pulse_done);

    a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_done |-> $past(pulse_busy));

    a_r11_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_busy |-> !cmd_accept);

endmodule

bind fclk_timebase fclk_timebase_chk #(.DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .loaded     (loaded),
    .acc_err    (acc_err),
    .tick       (tick),
    .div_q      (div_q),
    .pre_q      (pre_q),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .cmd_start  (cmd_start),
    .cmd_accept (cmd_accept),
    .pulse_busy (pulse_busy),
    .pulse_done (pulse_done)
);

// File: tb/sim_fclk_timebase.sv
`timescale 1ns/1ps
module sim_fclk_timebase;
    localparam int P_TICKS = 3;
    localparam int E_TICKS = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       cmd_start = 1'b0;
    logic       cmd_kind = 1'b0;
    logic       tick, cmd_accept, pulse_busy, pulse_done;

    int vectors = 0;
    int miscompares = 0;

    always #10 clk = ~clk;

    fclk_timebase #(
        .DIV_W(6), .PRE_RATIO(8), .PROG_TICKS(P_TICKS), .ERASE_TICKS(E_TICKS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_start(cmd_start),
        .cmd_kind(cmd_kind), .tick(tick), .cmd_accept(cmd_accept),
        .pulse_busy(pulse_busy), .pulse_done(pulse_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; reg_wr = 1'b0; cmd_start = 1'b0; reg_sel = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output int v);
        reg_sel = sel;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic run_cmd(input logic kind, input int n, input string tag);
        int ticks, last, k, bad;
        bit done;
        @(negedge clk);
        cmd_start = 1'b1; cmd_kind = kind;
        #1;
        chk(cmd_accept == 1'b1, "R9 accept when idle", int'(cmd_accept), 1);
        @(negedge clk);
        #1;
        chk(cmd_accept == 1'b0, "R11 start while busy refused", int'(cmd_accept), 0);
        ticks = 0; last = -5; k = 0; done = 1'b0; bad = 0;
        while (!done && k < 20000) begin
            if (pulse_done) begin
                done = 1'b1;
            end else begin
                if (!pulse_busy) bad++;
                if (tick) begin ticks++; last = k; end
                @(negedge clk);
                cmd_start = 1'b0;
                #1;
                k++;
            end
        end
        chk(done, {tag, " R10 done seen"}, int'(done), 1);
        chk(ticks == n, {tag, " R10 tick count"}, ticks, n);
        chk(last == k - 1, {tag, " R10 done follows last tick"}, last, k - 1);
        chk(bad == 0, {tag, " R10 busy held"}, bad, 0);
        @(negedge clk);
        #1;
        chk(!pulse_done && !pulse_busy, {tag, " R10 done single"}, int'(pulse_done), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int v, per, bad, dv;
        for (int pi = 0; pi < 2; pi++) begin
            for (int di = 0; di < 9; di++) begin
                dv  = (di == 8) ? 63 : di;
                per = (pi == 1 ? 8 : 1) * (dv + 1);
                do_reset();
                // R1 reset state
                rd(1'b0, v); chk(v == 0, "R1 divider reads 0", v, 0);
                rd(1'b1, v); chk(v == 0, "R1 status reads 0", v, 0);
                chk(!tick && !pulse_busy, "R1 outputs idle", int'(tick), 0);
                // R5 silent while unloaded
                bad = 0;
                for (int i = 0; i < 6; i++) begin
                    @(negedge clk); #1;
                    if (tick) bad++;
                end
                chk(bad == 0, "R5 no tick unloaded", bad, 0);
                // R7 early start
                @(negedge clk);
                cmd_start = 1'b1; cmd_kind = 1'b0;
                #1;
                chk(cmd_accept == 1'b0, "R7 early start refused", int'(cmd_accept), 0);
                @(negedge clk);
                cmd_start = 1'b0;
                rd(1'b1, v); chk(v == 8'h10, "R7 error flag set", v, 8'h10);
                // R4 write blocked by error
                wr(1'b0, 8'((pi << 6) | dv));
                rd(1'b0, v); chk(v == 0, "R4 write refused under error", v, 0);
                // R8 clear semantics
                wr(1'b1, 8'hEF);
                rd(1'b1, v); chk(v == 8'h10, "R8 zero write keeps error", v, 8'h10);
                wr(1'b1, 8'h10);
                rd(1'b1, v); chk(v == 0, "R8 one write clears error", v, 0);
                // R2 load (bit7 of write data set; read-only)
                wr(1'b0, 8'h80 | 8'((pi << 6) | dv));
                // now in cycle n=0 after the load edge
                bad = 0;
                for (int n = 0; n <= 3 * per; n++) begin
                    if (n == 0) begin
                        rd(1'b0, v);
                        chk(v == (8'h80 | (pi << 6) | dv), "R2 loaded readback", v,
                            8'h80 | (pi << 6) | dv);
                        chk(v == (8'h80 | (pi << 6) | dv), "R4 write accepted after clear", v,
                            8'h80 | (pi << 6) | dv);
                    end else begin
                        #1;
                    end
                    if (tick != ((n > 0) && (n % per == 0))) begin
                        if (bad == 0)
                            $display("FAIL R6 tick at n=%0d: actual %0d expected %0d", n,
                                     tick, !tick);
                        bad++;
                    end
                    @(negedge clk);
                end
                chk(bad == 0, "R6 tick phase and period", bad, 0);
                // R3 second write ignored
                wr(1'b0, 8'(~((pi << 6) | dv)));
                rd(1'b0, v);
                chk(v == (8'h80 | (pi << 6) | dv), "R3 second write ignored", v,
                    8'h80 | (pi << 6) | dv);
                // R10 program then erase, R11 start while busy
                run_cmd(1'b0, P_TICKS, "program");
                run_cmd(1'b1, E_TICKS, "erase");
                rd(1'b1, v); chk(v == 0, "R11 busy start sets no error", v, 0);
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule